// File: doc/BRIEF.md
# Frame Scanout Configuration Latch

This block sits between the display control registers and the scanout engine. On every frame-end pulse it samples the size, mode and configuration registers, decodes their packed fields, and holds a consistent set of scanout parameters for the whole of the next frame. The held set is: output enable, blanking, the border fill colour, the colour format, the horizontal and vertical resolution in pixels, the row stride in bytes and the frame start address. Register writes made during a frame therefore take effect only at the next frame boundary.

During the frame the block also produces the byte address of the current display line. This address is reloaded with the start address at frame end and moves forward by one row stride on each line-advance strobe. A one-cycle format-changed pulse tells downstream logic that the resolution or colour format differs from the previous frame, so that it can resize its buffers.

Top module: `scanout_cfg_latch`

## Requirements
- R1: After reset, every output is 0: enable, blank, fill colour, format, both resolutions, stride, base address, line address and the format-changed pulse.
- R2: The size register packs three CNT_W-bit fields. From the least significant end they are: the word count field W, the line count field L, and the modulo field M. Pixel words per line are W+1 and lines per field are L+1.
- R3: The latched row stride in bytes is ((W+1) + (M-1)) * 4, which equals (W+M)*4.
- R4: Mode register bits 3:2 select the format. Code 0 is ARGB1555 and 1 is RGB565, both giving horizontal resolution = words*2. Code 2 is packed RGB888, giving words*4/3 rounded down. Code 3 is ARGB8888, giving words.
- R5: When config register bit 4 (interlace) is set, the vertical resolution is 2*(L+1). Otherwise it is L+1.
- R6: Output is enabled only when mode register bit 0 and config register bit 0 are both 1. When it is disabled, both latched resolutions are 0.
- R7: The blank output equals bit 3 of the second config register, and the fill colour output equals the border colour input, both as sampled at frame end.
- R8: Latched parameters change only on a cycle with frame_end. Register changes on other cycles have no effect on the outputs.
- R9: fmt_changed is high for exactly the one cycle after a frame-end sample whose resolutions or format differ from the previously held values. Otherwise it is low.
- R10: On frame_end, line_addr loads the start address sampled in that cycle. This takes priority over a simultaneous line_adv.
- R11: Each line_adv without frame_end adds the held stride to line_addr, modulo 2^ADDR_W. With neither strobe, line_addr holds its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| frame_end | input | 1 | Frame boundary strobe; samples the registers |
| line_adv | input | 1 | Advance to the next display line |
| size_reg | input | 32 | Packed word count, line count and modulo fields |
| mode_reg | input | 32 | Display enable (bit 0), format (bits 3:2) |
| cfg_reg | input | 32 | Video out (bit 0), interlace (bit 4) |
| cfg2_reg | input | 32 | Blank request (bit 3) |
| border_colour | input | COLOUR_W | Colour shown while blanked |
| start_addr | input | ADDR_W | Frame start address |
| out_en | output | 1 | Held output enable |
| blank | output | 1 | Held blank state |
| fill_colour | output | COLOUR_W | Held border colour |
| fmt | output | 2 | Held colour format code |
| hres | output | CNT_W+2 | Held horizontal resolution |
| vres | output | CNT_W+2 | Held vertical resolution |
| stride | output | CNT_W+3 | Held row stride in bytes |
| base_addr | output | ADDR_W | Held start address |
| line_addr | output | ADDR_W | Current line address |
| fmt_changed | output | 1 | One-cycle resolution/format change pulse |

## Verification
The bench keeps CNT_W at 10, so the all-ones size fields give the largest resolutions (2048 wide, 2048 tall interlaced) and the largest stride. The all-zero fields give the smallest packed-24-bit width of 1 and a stride of 0. ADDR_W is reduced to 16 so that a single line step from near the top of the address space shows the wrap. COLOUR_W stays at 24.

// File: rtl/scanout_pkg.sv
package scanout_pkg;
    typedef enum logic [1:0] {
        FMT_1555 = 2'd0,
        FMT_565  = 2'd1,
        FMT_888  = 2'd2,
        FMT_8888 = 2'd3
    } fmt_e;

    localparam int MODE_EN_BIT   = 0;
    localparam int MODE_FMT_LSB  = 2;
    localparam int CFG_VOUT_BIT  = 0;
    localparam int CFG_ILACE_BIT = 4;
    localparam int CFG2_BLANK_BIT = 3;
endpackage

// File: rtl/scanout_size_decode.sv
module scanout_size_decode
    import scanout_pkg::*;
#(
    parameter int CNT_W = 10
) (
    input  logic [31:0]          size_word,
    input  logic [31:0]          mode_word,
    input  logic [31:0]          cfg_word,
    output logic                 en,
    output fmt_e                 fmt,
    output logic [CNT_W+1:0]     hres,
    output logic [CNT_W+1:0]     vres,
    output logic [CNT_W+2:0]     stride
);
    localparam int WW = CNT_W + 1;
    localparam int PW = CNT_W + 3;

    logic [CNT_W-1:0] w_fld, l_fld, m_fld;
    logic [WW-1:0]    words, lines;
    logic [PW-1:0]    words_x4, words_x4_div3;
    logic [CNT_W+1:0] h_raw, v_raw;
    logic             unused_bits;

    assign unused_bits = ^{size_word, mode_word, cfg_word};

    always_comb begin
        w_fld = size_word[CNT_W-1:0];
        l_fld = size_word[2*CNT_W-1:CNT_W];
        m_fld = size_word[3*CNT_W-1:2*CNT_W];
        words = {1'b0, w_fld} + WW'(1);
        lines = {1'b0, l_fld} + WW'(1);
        en    = mode_word[MODE_EN_BIT] & cfg_word[CFG_VOUT_BIT];
        fmt   = fmt_e'(mode_word[MODE_FMT_LSB +: 2]);
        words_x4      = {words, 2'b00};
        words_x4_div3 = words_x4 / PW'(3);
        case (fmt)
            FMT_888:  h_raw = words_x4_div3[CNT_W+1:0];
            FMT_8888: h_raw = {1'b0, words};
            default:  h_raw = {words, 1'b0};
        endcase
        v_raw  = cfg_word[CFG_ILACE_BIT] ? {lines, 1'b0} : {1'b0, lines};
        hres   = en ? h_raw : '0;
        vres   = en ? v_raw : '0;
        stride = {({1'b0, w_fld} + {1'b0, m_fld}), 2'b00};
    end
endmodule

// File: rtl/scanout_line_seq.sv
module scanout_line_seq #(
    parameter int ADDR_W   = 24,
    parameter int STRIDE_W = 13
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                frame_end,
    input  logic                line_adv,
    input  logic [ADDR_W-1:0]   start_addr,
    input  logic [STRIDE_W-1:0] stride_i,
    output logic [ADDR_W-1:0]   line_addr
);
    logic [ADDR_W-1:0] addr_d, addr_q;

    always_comb begin
        addr_d = addr_q;
        if (frame_end)
            addr_d = start_addr;
        else if (line_adv)
            addr_d = addr_q + ADDR_W'(stride_i);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) addr_q <= '0;
        else        addr_q <= addr_d;
    end

    assign line_addr = addr_q;

    p_restart_r10: assert property (@(posedge clk) disable iff (!rst_n)
        frame_end |=> line_addr == $past(start_addr));

    p_idle_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (!frame_end && !line_adv) |=> $stable(line_addr));
endmodule

// File: rtl/scanout_cfg_latch.sv
module scanout_cfg_latch
    import scanout_pkg::*;
#(
    parameter int CNT_W    = 10,
    parameter int ADDR_W   = 24,
    parameter int COLOUR_W = 24
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                frame_end,
    input  logic                line_adv,
    input  logic [31:0]         size_reg,
    input  logic [31:0]         mode_reg,
    input  logic [31:0]         cfg_reg,
    input  logic [31:0]         cfg2_reg,
    input  logic [COLOUR_W-1:0] border_colour,
    input  logic [ADDR_W-1:0]   start_addr,
    output logic                out_en,
    output logic                blank,
    output logic [COLOUR_W-1:0] fill_colour,
    output logic [1:0]          fmt,
    output logic [CNT_W+1:0]    hres,
    output logic [CNT_W+1:0]    vres,
    output logic [CNT_W+2:0]    stride,
    output logic [ADDR_W-1:0]   base_addr,
    output logic [ADDR_W-1:0]   line_addr,
    output logic                fmt_changed
);
    localparam int RES_W    = CNT_W + 2;
    localparam int STRIDE_W = CNT_W + 3;

    typedef struct packed {
        logic                en;
        logic                blank;
        logic [COLOUR_W-1:0] fill;
        fmt_e                fmt;
        logic [RES_W-1:0]    hres;
        logic [RES_W-1:0]    vres;
        logic [STRIDE_W-1:0] stride;
        logic [ADDR_W-1:0]   base;
        logic                chg;
    } held_t;

    held_t st_d, st_q;

    logic                dec_en;
    fmt_e                dec_fmt;
    logic [RES_W-1:0]    dec_hres, dec_vres;
    logic [STRIDE_W-1:0] dec_stride;
    logic                unused_cfg2;

    assign unused_cfg2 = ^cfg2_reg;

    scanout_size_decode #(.CNT_W(CNT_W)) u_dec (
        .size_word (size_reg),
        .mode_word (mode_reg),
        .cfg_word  (cfg_reg),
        .en        (dec_en),
        .fmt       (dec_fmt),
        .hres      (dec_hres),
        .vres      (dec_vres),
        .stride    (dec_stride)
    );

    always_comb begin
        st_d     = st_q;
        st_d.chg = 1'b0;
        if (frame_end) begin
            st_d.en     = dec_en;
            st_d.blank  = cfg2_reg[CFG2_BLANK_BIT];
            st_d.fill   = border_colour;
            st_d.fmt    = dec_fmt;
            st_d.hres   = dec_hres;
            st_d.vres   = dec_vres;
            st_d.stride = dec_stride;
            st_d.base   = start_addr;
            st_d.chg    = (dec_hres != st_q.hres) || (dec_vres != st_q.vres)
                          || (dec_fmt != st_q.fmt);
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    scanout_line_seq #(.ADDR_W(ADDR_W), .STRIDE_W(STRIDE_W)) u_line (
        .clk        (clk),
        .rst_n      (rst_n),
        .frame_end  (frame_end),
        .line_adv   (line_adv),
        .start_addr (start_addr),
        .stride_i   (st_q.stride),
        .line_addr  (line_addr)
    );

    assign out_en      = st_q.en;
    assign blank       = st_q.blank;
    assign fill_colour = st_q.fill;
    assign fmt         = st_q.fmt;
    assign hres        = st_q.hres;
    assign vres        = st_q.vres;
    assign stride      = st_q.stride;
    assign base_addr   = st_q.base;
    assign fmt_changed = st_q.chg;

    p_off_zero_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !out_en |-> (hres == '0 && vres == '0));

    p_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !frame_end |=> ($stable(hres) && $stable(vres) && $stable(fmt)
                        && $stable(stride) && $stable(base_addr)));

    p_chg_pulse_r9: assert property (@(posedge clk) disable iff (!rst_n)
        fmt_changed |-> $past(frame_end));

    p_chg_single_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !frame_end |=> !fmt_changed);
endmodule

// File: tb/scanout_cfg_latch_tb.sv
`timescale 1ns/1ps
module scanout_cfg_latch_tb;
    localparam int CNT_W = 10;
    localparam int ADDR_W = 16;
    localparam int COLOUR_W = 24;

    typedef struct packed {
        logic [31:0] size;
        logic [31:0] mode;
        logic [31:0] cfg;
        logic [31:0] cfg2;
        logic [23:0] border;
        logic [15:0] start;
        logic        en;
        logic        blank;
        logic [1:0]  fmt;
        logic [11:0] hres;
        logic [11:0] vres;
        logic [12:0] stride;
    } vec_t;

    // size = {2'b0, M, L, W}
    localparam vec_t VECS [9] = '{
        '{{2'b0,10'd1,10'd479,10'd639},   32'h5, 32'h1,  32'h0, 24'h0,      16'h1000, 1'b1, 1'b0, 2'd1, 12'd1280, 12'd480,  13'd2560},
        '{{2'b0,10'd0,10'd239,10'd319},   32'hD, 32'h11, 32'h0, 24'h0,      16'h2000, 1'b1, 1'b0, 2'd3, 12'd320,  12'd480,  13'd1276},
        '{{2'b0,10'd5,10'd479,10'd479},   32'h9, 32'h1,  32'h0, 24'h0,      16'h3000, 1'b1, 1'b0, 2'd2, 12'd640,  12'd480,  13'd1936},
        '{{2'b0,10'd1023,10'd1023,10'd1023}, 32'h1, 32'h11, 32'h0, 24'h0,   16'h4000, 1'b1, 1'b0, 2'd0, 12'd2048, 12'd2048, 13'd8184},
        '{{2'b0,10'd0,10'd0,10'd0},       32'h9, 32'h1,  32'h0, 24'h0,      16'h0010, 1'b1, 1'b0, 2'd2, 12'd1,    12'd1,    13'd0},
        '{{2'b0,10'd3,10'd9,10'd99},      32'h4, 32'h1,  32'h0, 24'h0,      16'h0020, 1'b0, 1'b0, 2'd1, 12'd0,    12'd0,    13'd408},
        '{{2'b0,10'd3,10'd9,10'd99},      32'h5, 32'h10, 32'h0, 24'h0,      16'h0030, 1'b0, 1'b0, 2'd1, 12'd0,    12'd0,    13'd408},
        '{{2'b0,10'd1,10'd9,10'd9},       32'hD, 32'h1,  32'h8, 24'hABCDEF, 16'h0040, 1'b1, 1'b1, 2'd3, 12'd10,   12'd10,   13'd40},
        '{{2'b0,10'd1,10'd9,10'd2},       32'h9, 32'h1,  32'h7, 24'h123456, 16'h0050, 1'b1, 1'b0, 2'd2, 12'd4,    12'd10,   13'd12}
    };

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic frame_end = 1'b0, line_adv = 1'b0;
    logic [31:0] size_reg = '0, mode_reg = '0, cfg_reg = '0, cfg2_reg = '0;
    logic [COLOUR_W-1:0] border_colour = '0;
    logic [ADDR_W-1:0] start_addr = '0;
    logic out_en, blank, fmt_changed;
    logic [COLOUR_W-1:0] fill_colour;
    logic [1:0] fmt;
    logic [CNT_W+1:0] hres, vres;
    logic [CNT_W+2:0] stride;
    logic [ADDR_W-1:0] base_addr, line_addr;

    int n_chk = 0, n_err = 0;
    bit done = 0;

    always #2.5 clk = ~clk;

    scanout_cfg_latch #(.CNT_W(CNT_W), .ADDR_W(ADDR_W), .COLOUR_W(COLOUR_W)) u_dut (
        .clk(clk), .rst_n(rst_n), .frame_end(frame_end), .line_adv(line_adv),
        .size_reg(size_reg), .mode_reg(mode_reg), .cfg_reg(cfg_reg), .cfg2_reg(cfg2_reg),
        .border_colour(border_colour), .start_addr(start_addr),
        .out_en(out_en), .blank(blank), .fill_colour(fill_colour), .fmt(fmt),
        .hres(hres), .vres(vres), .stride(stride), .base_addr(base_addr),
        .line_addr(line_addr), .fmt_changed(fmt_changed)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
            $finish;
        end
    endtask

    task automatic load_regs(input vec_t v);
        size_reg = v.size; mode_reg = v.mode; cfg_reg = v.cfg;
        cfg2_reg = v.cfg2; border_colour = v.border; start_addr = v.start;
    endtask

    // pulse frame_end (optionally with line_adv); returns at the negedge after the sampling edge
    task automatic frame_pulse(input logic with_line);
        @(negedge clk);
        frame_end = 1'b1; line_adv = with_line;
        @(posedge clk);
        @(negedge clk);
        frame_end = 1'b0; line_adv = 1'b0;
    endtask

    task automatic step_line();
        @(negedge clk); line_adv = 1'b1;
        @(negedge clk); line_adv = 1'b0;
    endtask

    initial begin
        #200000;
        n_chk++; n_err++;
        $display("FAIL watchdog actual=running expected=done");
        finish_run();
    end

    initial begin
        logic [11:0] ph, pv;
        logic [1:0]  pf;
        logic [11:0] keep_h;
        logic [15:0] keep_a;
        repeat (3) @(posedge clk);
        @(negedge clk);
        // R1: reset state
        chk("R1 out_en", out_en, 0);
        chk("R1 hres", hres, 0);
        chk("R1 vres", vres, 0);
        chk("R1 stride", stride, 0);
        chk("R1 line_addr", line_addr, 0);
        chk("R1 fmt_changed", fmt_changed, 0);
        chk("R1 fill", fill_colour, 0);
        rst_n = 1'b1;
        ph = 0; pv = 0; pf = 0;

        foreach (VECS[i]) begin
            load_regs(VECS[i]);
            frame_pulse(1'b0);
            chk("R6 out_en", out_en, VECS[i].en);
            chk("R4 fmt", fmt, VECS[i].fmt);
            chk("R4 R2 hres", hres, VECS[i].hres);
            chk("R5 R2 vres", vres, VECS[i].vres);
            chk("R3 stride", stride, VECS[i].stride);
            chk("R7 blank", blank, VECS[i].blank);
            chk("R7 fill", fill_colour, VECS[i].border);
            chk("R10 base", base_addr, VECS[i].start);
            chk("R10 line_addr", line_addr, VECS[i].start);
            chk("R9 pulse", fmt_changed,
                (VECS[i].hres != ph) || (VECS[i].vres != pv) || (VECS[i].fmt != pf));
            @(negedge clk);
            chk("R9 single cycle", fmt_changed, 0);
            ph = VECS[i].hres; pv = VECS[i].vres; pf = VECS[i].fmt;
        end

        // R8: register changes without frame_end are ignored
        keep_h = hres; keep_a = line_addr;
        load_regs(VECS[0]);
        repeat (3) @(negedge clk);
        chk("R8 hres held", hres, keep_h);
        chk("R8 fmt held", fmt, 2'd2);
        chk("R11 line idle", line_addr, keep_a);

        // R9: first frame with VECS[0] changes format, second identical frame does not
        frame_pulse(1'b0);
        chk("R9 change", fmt_changed, 1);
        frame_pulse(1'b0);
        chk("R9 no change", fmt_changed, 0);

        // R11: stepping by stride 2560 from 0x1000
        repeat (3) step_line();
        chk("R11 three steps", line_addr, 16'h2E00);

        // R11: wrap modulo 2^ADDR_W
        start_addr = 16'hFF00;
        frame_pulse(1'b0);
        chk("R10 reload", line_addr, 16'hFF00);
        step_line();
        chk("R11 wrap", line_addr, 16'h0900);

        // R10: frame_end beats simultaneous line_adv
        start_addr = 16'h0040;
        frame_pulse(1'b1);
        chk("R10 priority", line_addr, 16'h0040);

        finish_run();
    end
endmodule